// File: doc/BRIEF.md
# Trimmed Seconds Prescaler

This block takes the free-running crystal oscillator clock and produces a one-cycle pulse once per second. The timekeeping counters downstream use that pulse to advance the seconds. Crystals are never exactly on frequency, so the block can make selected seconds longer or shorter by an even number of oscillator cycles. It changes only the seconds whose BCD value is 00, 20 or 40, which means a correction is applied three times a minute. One correction step is two cycles, about 3 ppm. An 8-bit trimming word sets two things: the crystal type (32.768 kHz or 32.000 kHz nominal) and a 7-bit signed correction code. The raw oscillator clock is passed straight to a separate output and is never trimmed.

The length of a second is fixed on that second's first cycle, from the trimming word and the seconds value at that moment. If the trimming word is written during a second, the new value takes effect at the next boundary. Changing the crystal type restarts the count at zero, so the count never runs past the new nominal length.

Top module: `tt_prescaler`

## Requirements
- R1: While `rst` is high, `sec_tick` stays low. After `rst` is released, the count starts from zero and the first second has the length selected by the inputs on its first cycle.
- R2: An untrimmed second lasts `NOM_A` cycles (32768 by default) when `trim_cfg[7]` is 0, and `NOM_B` cycles (32000 by default) when `trim_cfg[7]` is 1.
- R3: Trimming applies only when `sec_bcd` is 8'h00, 8'h20 or 8'h40 on the first cycle of the second. Every other seconds value gives the nominal length.
- R4: In a trim second with `trim_cfg[6]` = 0 and `trim_cfg[5:1]` not all zero, the length is nominal + 2 × (`trim_cfg[5:0]` − 1). For example, code 7'b0000111 gives nominal + 12.
- R5: In a trim second with `trim_cfg[6]` = 1 and `trim_cfg[5:1]` not all zero, the length is nominal − 2 × (64 − `trim_cfg[5:0]`). For example, code 7'b1111110 gives nominal − 4 and code 7'b1000010 gives nominal − 124.
- R6: When `trim_cfg[5:1]` is all zero, the length is nominal, whatever the values of `trim_cfg[6]` and `trim_cfg[0]`.
- R7: `sec_tick` is high for exactly one cycle, on the last cycle of the selected length, so consecutive ticks are exactly one second-length apart.
- R8: A change to `trim_cfg[6:0]` or `sec_bcd` after the first cycle of a second does not alter that second's length. It applies from the next second.
- R9: When `trim_cfg[7]` changes, the count restarts from zero at the next clock edge, and the restarted second has the length given by the new setting.
- R10: `clk32_out` always equals `osc_clk`, whatever the trimming word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Crystal oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| trim_cfg | input | 8 | Bit 7 = crystal select (0: NOM_A, 1: NOM_B); bit 6 = correction sign; bits 5:0 = correction magnitude field |
| sec_bcd | input | 8 | Current seconds value in BCD, from the timekeeping counter |
| sec_tick | output | 1 | One-cycle pulse on the last cycle of each second |
| clk32_out | output | 1 | Untrimmed oscillator clock pass-through |

## Verification
Any fault in the counter, in the latched length or in the trim decode changes the spacing between two ticks. So every error shows up as a tick that comes early, late or not at all, and it shows up by the end of the affected second. Latching the wrong seconds value or trimming word appears only in the second that follows the bad capture, so each trim second is set up one second ahead and then measured in full. A missed or spurious restart on a crystal change shows up on the next tick, measured from the change.

// File: rtl/tt_prescale_pkg.sv
package tt_prescale_pkg;

    localparam int MAG_W     = 6;
    localparam int CODE_W    = MAG_W + 1;
    localparam int CFG_W     = CODE_W + 1;
    localparam int SEC_W     = 8;
    localparam int MAX_STEPS = (1 << MAG_W) - 2;
    localparam int MAX_ADJ   = 2 * MAX_STEPS;

    localparam logic [SEC_W-1:0] WIN_SEC0 = 8'h00;
    localparam logic [SEC_W-1:0] WIN_SEC1 = 8'h20;
    localparam logic [SEC_W-1:0] WIN_SEC2 = 8'h40;

    typedef struct packed {
        logic             xsel;
        logic             sign;
        logic [MAG_W-1:0] mag;
    } trim_word_t;

    typedef enum logic [1:0] {
        ADJ_NONE = 2'd0,
        ADJ_SLOW = 2'd1,
        ADJ_FAST = 2'd2
    } adj_kind_e;

    typedef struct packed {
        adj_kind_e        kind;
        logic [MAG_W-1:0] steps;
    } adj_t;

    // Signed code to a direction plus a step count (one step = 2 cycles).
    function automatic adj_t decode_trim(input logic sign, input logic [MAG_W-1:0] mag);
        adj_t a;
        a.kind  = ADJ_NONE;
        a.steps = '0;
        if (mag[MAG_W-1:1] != '0) begin
            if (!sign) begin
                a.kind  = ADJ_SLOW;
                a.steps = mag - MAG_W'(1);
            end else begin
                a.kind  = ADJ_FAST;
                a.steps = ~mag + MAG_W'(1);
            end
        end
        return a;
    endfunction

    function automatic logic is_trim_second(input logic [SEC_W-1:0] s);
        return (s == WIN_SEC0) || (s == WIN_SEC1) || (s == WIN_SEC2);
    endfunction

endpackage

// File: rtl/tt_trim_decode.sv
module tt_trim_decode
    import tt_prescale_pkg::*;
(
    input  logic [CFG_W-1:0] cfg_i,
    output logic             xsel_o,
    output adj_t             adj_o
);
    trim_word_t word;

    assign word   = trim_word_t'(cfg_i);
    assign xsel_o = word.xsel;

    always_comb begin
        adj_o = decode_trim(word.sign, word.mag);
    end

endmodule

// File: rtl/tt_len_select.sv
module tt_len_select
    import tt_prescale_pkg::*;
#(
    parameter int NOM_A = 32768,
    parameter int NOM_B = 32000,
    parameter int CNT_W = 16
) (
    input  logic             xsel_i,
    input  adj_t             adj_i,
    input  logic [SEC_W-1:0] sec_i,
    output logic [CNT_W-1:0] len_o
);
    logic [CNT_W-1:0] nom;
    logic [CNT_W-1:0] span;
    logic             window;

    generate
        if (NOM_A == NOM_B) begin : g_single_nom
            assign nom = CNT_W'(NOM_A);
        end else begin : g_dual_nom
            assign nom = xsel_i ? CNT_W'(NOM_B) : CNT_W'(NOM_A);
        end
    endgenerate

    assign span   = CNT_W'({adj_i.steps, 1'b0});
    assign window = is_trim_second(sec_i);

    always_comb begin
        len_o = nom;
        if (window) begin
            unique case (adj_i.kind)
                ADJ_SLOW: len_o = nom + span;
                ADJ_FAST: len_o = nom - span;
                default:  len_o = nom;
            endcase
        end
    end

endmodule

// File: rtl/tt_sec_counter.sv
module tt_sec_counter
    import tt_prescale_pkg::*;
#(
    parameter int NOM_A = 32768,
    parameter int NOM_B = 32000,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xsel_i,
    input  logic [CNT_W-1:0] len_next_i,
    output logic             tick_o
);
    localparam logic [CNT_W-1:0] LO_A = CNT_W'(NOM_A - MAX_ADJ);
    localparam logic [CNT_W-1:0] HI_A = CNT_W'(NOM_A + MAX_ADJ);
    localparam logic [CNT_W-1:0] LO_B = CNT_W'(NOM_B - MAX_ADJ);
    localparam logic [CNT_W-1:0] HI_B = CNT_W'(NOM_B + MAX_ADJ);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_q;
    logic             xsel_q;
    logic             restart;
    logic             at_start;
    logic             at_end;

    assign restart  = (xsel_i != xsel_q);
    assign at_start = (cnt_q == '0);
    assign at_end   = !at_start && (cnt_q == len_q - CNT_W'(1));
    assign tick_o   = at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            len_q  <= '0;
            xsel_q <= xsel_i;
        end else if (restart) begin
            cnt_q  <= '0;
            xsel_q <= xsel_i;
        end else if (at_start) begin
            len_q <= len_next_i;
            cnt_q <= CNT_W'(1);
        end else if (at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R7: a tick never lasts two cycles
    a_r7_single_tick: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

    // R7: the running count stays below the latched length
    a_r7_count_in_range: assert property (@(posedge clk) disable iff (rst)
        !at_start |-> (cnt_q < len_q));

    // R1: the first cycle after reset is a second boundary with no tick
    a_r1_start_clean: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (at_start && !tick_o));

    // R9: a crystal change forces the count back to zero
    a_r9_restart: assert property (@(posedge clk) disable iff (rst)
        restart |=> at_start);

    // R8: the latched length is held for the whole second
    a_r8_len_held: assert property (@(posedge clk) disable iff (rst)
        (!at_start && !$past(rst) && ($past(cnt_q) != '0)) |-> $stable(len_q));

    // R2: the latched length lies within the trim span of the active nominal
    a_r2_len_bounds: assert property (@(posedge clk) disable iff (rst)
        !at_start |-> (xsel_q ? (len_q >= LO_B && len_q <= HI_B)
                              : (len_q >= LO_A && len_q <= HI_A)));

endmodule

// File: rtl/tt_prescaler.sv
module tt_prescaler
    import tt_prescale_pkg::*;
#(
    parameter int NOM_A = 32768,
    parameter int NOM_B = 32000
) (
    input  logic             osc_clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] trim_cfg,
    input  logic [SEC_W-1:0] sec_bcd,
    output logic             sec_tick,
    output logic             clk32_out
);
    localparam int NOM_MAX = (NOM_A > NOM_B) ? NOM_A : NOM_B;
    localparam int CNT_W   = $clog2(NOM_MAX + MAX_ADJ + 1);

    logic             xsel;
    adj_t             adj;
    logic [CNT_W-1:0] len_next;

    tt_trim_decode i_decode (
        .cfg_i  (trim_cfg),
        .xsel_o (xsel),
        .adj_o  (adj)
    );

    tt_len_select #(
        .NOM_A (NOM_A),
        .NOM_B (NOM_B),
        .CNT_W (CNT_W)
    ) i_len (
        .xsel_i (xsel),
        .adj_i  (adj),
        .sec_i  (sec_bcd),
        .len_o  (len_next)
    );

    tt_sec_counter #(
        .NOM_A (NOM_A),
        .NOM_B (NOM_B),
        .CNT_W (CNT_W)
    ) i_count (
        .clk        (osc_clk),
        .rst        (rst),
        .xsel_i     (xsel),
        .len_next_i (len_next),
        .tick_o     (sec_tick)
    );

    // R10: raw oscillator clock, never trimmed
    assign clk32_out = osc_clk;

endmodule

// File: tb/test_tt_prescaler.sv
module test_tt_prescaler;

    localparam int NA = 300;
    localparam int NB = 250;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] trim_cfg = 8'h00;
    logic [7:0] sec_bcd = 8'h10;
    logic       sec_tick;
    logic       clk32_out;

    int checks = 0;
    int failures = 0;

    logic [7:0] ovr_sec = 8'h00;
    bit         ovr_v = 1'b0;
    string      pend_tag = "R1";

    tt_prescaler #(.NOM_A(NA), .NOM_B(NB)) i_tt_prescaler (
        .osc_clk   (clk),
        .rst       (rst),
        .trim_cfg  (trim_cfg),
        .sec_bcd   (sec_bcd),
        .sec_tick  (sec_tick),
        .clk32_out (clk32_out)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] bcd_inc(input logic [7:0] s);
        if (s == 8'h59) return 8'h00;
        if (s[3:0] == 4'd9) return {s[7:4] + 4'd1, 4'd0};
        return s + 8'd1;
    endfunction

    function automatic bit in_window(input logic [7:0] s);
        return s == 8'h00 || s == 8'h20 || s == 8'h40;
    endfunction

    function automatic int exp_len(input logic [7:0] t, input logic [7:0] s);
        int nom = t[7] ? NB : NA;
        int f = int'(t[5:0]);
        if (!in_window(s)) return nom;
        if (t[5:1] == 5'd0) return nom;
        if (!t[6]) return nom + 2 * (f - 1);
        return nom - 2 * (64 - f);
    endfunction

    function automatic string tag_for(input logic [7:0] t, input logic [7:0] s);
        if (!in_window(s)) return "R3";
        if (t[5:1] == 5'd0) return "R6";
        if (!t[6]) return "R4";
        return "R5";
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv, input string what);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // seconds counter model standing in for the timekeeper
    always @(posedge clk) begin
        if (!rst && sec_tick) begin
            sec_bcd <= ovr_v ? ovr_sec : bcd_inc(sec_bcd);
            ovr_v   <= 1'b0;
        end
    end

    // length monitor: counts cycles of each second from its first cycle
    bit    start = 1'b1;
    bit    restarted = 1'b0;
    bit    prev_tick = 1'b0;
    logic  xs_prev = 1'b0;
    int    k = 0;
    int    expv = 0;
    string cur_tag = "R1";

    always @(negedge clk) begin
        if (rst) begin
            start = 1'b1;
            restarted = 1'b0;
            prev_tick = 1'b0;
            xs_prev = trim_cfg[7];
        end else begin
            if (prev_tick) chk(sec_tick == 1'b0, "R7", int'(sec_tick), 0, "tick wider than one cycle");
            if (start) begin
                k = 0;
                expv = exp_len(trim_cfg, sec_bcd);
                if (restarted) cur_tag = "R9";
                else if (pend_tag != "") begin cur_tag = pend_tag; pend_tag = ""; end
                else cur_tag = tag_for(trim_cfg, sec_bcd);
                restarted = 1'b0;
                start = 1'b0;
            end else begin
                k++;
            end
            if (sec_tick) begin
                chk(k == expv - 1, cur_tag, k + 1, expv, "second length");
                start = 1'b1;
            end
            if (trim_cfg[7] != xs_prev) begin
                start = 1'b1;
                restarted = 1'b1;
            end
            xs_prev = trim_cfg[7];
            prev_tick = sec_tick;
        end
    end

    task automatic wait_tick();
        do @(negedge clk); while (!sec_tick);
    endtask

    // program the word now, force the next second's value, then measure that second
    task automatic sec_with(input logic [7:0] t, input logic [7:0] s, input string tag);
        repeat (3) @(posedge clk);
        #2;
        trim_cfg = t;
        ovr_sec  = s;
        ovr_v    = 1'b1;
        pend_tag = tag;
        wait_tick();
        wait_tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL R7 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: no tick while reset is held
        repeat (3) @(posedge clk);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(sec_tick == 1'b0, "R1", int'(sec_tick), 0, "tick during reset");
        end
        @(posedge clk); #2;
        rst = 1'b0;
        wait_tick(); // R1: first second checked by the monitor

        // R10: pass-through clock
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            chk(clk32_out == 1'b1, "R10", int'(clk32_out), 1, "clock high phase");
            @(negedge clk); #1;
            chk(clk32_out == 1'b0, "R10", int'(clk32_out), 0, "clock low phase");
        end

        sec_with(8'h00, 8'h15, "R2");
        sec_with(8'h07, 8'h00, "R4");
        sec_with(8'h3F, 8'h20, "R4");
        sec_with(8'h7E, 8'h40, "R5");
        sec_with(8'h42, 8'h00, "R5");
        sec_with(8'h01, 8'h00, "R6");
        sec_with(8'h41, 8'h20, "R6");
        sec_with(8'h40, 8'h40, "R6");
        sec_with(8'h07, 8'h01, "R3");
        sec_with(8'h07, 8'h30, "R3");
        sec_with(8'h7E, 8'h41, "R3");

        // R8: rewrite mid-second in a trim second
        repeat (3) @(posedge clk); #2;
        trim_cfg = 8'h07; ovr_sec = 8'h20; ovr_v = 1'b1; pend_tag = "R8";
        wait_tick();
        repeat (50) @(posedge clk); #2;
        trim_cfg = 8'h7E;
        wait_tick();

        // R9 then R2 at the second crystal setting
        repeat (40) @(posedge clk); #2;
        trim_cfg = 8'h80;
        wait_tick();
        sec_with(8'h80, 8'h33, "R2");
        sec_with(8'h87, 8'h20, "R4");
        sec_with(8'hFE, 8'h40, "R5");
        sec_with(8'h00, 8'h12, "R9");

        // random mix
        for (int i = 0; i < 90; i++) begin
            logic [7:0] t;
            logic [7:0] s;
            t[6:0] = 7'($urandom % 128);
            t[7] = (($urandom % 8) == 0) ? ~trim_cfg[7] : trim_cfg[7];
            case ($urandom % 4)
                0: s = 8'h00;
                1: s = 8'h20;
                2: s = 8'h40;
                default: s = {4'($urandom % 6), 4'($urandom % 10)};
            endcase
            sec_with(t, s, "");
        end

        repeat (5) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule